// File: doc/BRIEF.md
# Triggered Hit Pipeline Readout

The block keeps a short history of the binary hit pattern from every detector channel. One entry is written for each bunch crossing into a circular buffer, and the write position moves forward after each write. When a level-1 trigger strobe arrives, the block reads the entry written a programmable number of crossings earlier and stores it in a small derandomising queue. It adds a running trigger number and two error flags to the entry. It then sends the result as a serial packet on a single line.

The block runs on the fast bit clock, eight cycles per bunch crossing. A one-cycle strobe `bx_en` marks the cycle in which the hit vector and the trigger are sampled. The serial line carries one bit per bit-clock cycle, which gives eight bits per crossing. Between packets the line stays at zero, and every packet begins with two ones. A receiver therefore only needs the fixed packet length to split the stream into packets.

Top module: `hit_readout`

## Requirements
- R1: When a trigger is sampled at crossing n with latency L (1 ≤ L ≤ DEPTH−1), the packet carries the hit vector that was sampled at crossing n−L.
- R2: A packet is NCH+13 bits long and is sent most significant field first, one bit per clock. The fields are, in order: the header `11`, the 2-bit error field, the 9-bit trigger number (MSB first), then channel 0, channel 1, up to channel NCH−1.
- R3: The trigger number in the first packet after reset is 0. It goes up by one for each trigger that is accepted into the queue, and it wraps from 511 to 0.
- R4: The queue holds up to FIFO_DEPTH pending triggers. Packets leave in the order of their triggers, and no trigger is lost while the queue has room.
- R5: A trigger that arrives while the queue is full is dropped. The drop sets `overflow`, which stays at 1 until reset. Every packet accepted after the drop has bit 1 of its error field (the first error bit sent) set.
- R6: Bit 0 of the error field (the second error bit sent) is 1 exactly when the latency was 0 at the moment the trigger was sampled.
- R7: The serial line is 0 whenever no packet is being sent, and at least one 0 bit separates two packets.
- R8: `busy` is 1 while a trigger is queued or a packet is being sent. It is 0 once everything has drained.
- R9: While reset is held, and right after it is released, `ser_out`, `busy` and `overflow` are 0.
- R10: `hits` and `trig` are sampled only in cycles where `bx_en` is high. Values on them in other cycles produce no packet and do not alter stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, eight cycles per bunch crossing |
| rst | input | 1 | Synchronous active-high reset |
| bx_en | input | 1 | One-cycle strobe marking the sampling cycle of each crossing |
| hits | input | NCH | Binary hit vector, one bit per channel |
| trig | input | 1 | Level-1 trigger, sampled with `bx_en` |
| latency | input | $clog2(DEPTH) | Trigger latency in crossings |
| ser_out | output | 1 | Serial packet stream |
| busy | output | 1 | A trigger is queued or a packet is in flight |
| overflow | output | 1 | Sticky flag: a trigger was dropped on a full queue |

## Verification
The bench aims at the latency extremes 1 and DEPTH−1. An error in the read-address arithmetic shows up there as a packet that carries the vector one crossing off, or from a full buffer turn earlier. It sends more than 512 accepted triggers so that the counter must wrap, and a design that misses the wrap sends a wrong trigger number. A burst of back-to-back triggers overfills the queue: a design without the drop either corrupts the queue or loses the sticky flag, and the error bit is then missing from later packets. Stray triggers and changing hit values between strobes would appear as extra packets or wrong data in a design that samples outside `bx_en`.

// File: rtl/hitro_pkg.sv
package hitro_pkg;
  localparam int CNT_W = 9;
  localparam int ERR_W = 2;
  localparam int HDR_W = 2;
  localparam logic [HDR_W-1:0] START_HDR = 2'b11;
  localparam int OVH_W = HDR_W + ERR_W + CNT_W;

  typedef logic [CNT_W-1:0] trig_cnt_t;
endpackage

// File: rtl/hitro_pipe_ram.sv
module hitro_pipe_ram #(
  parameter int NCH   = 254,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [NCH-1:0] wdata,
  input  logic           re,
  input  logic [AW-1:0]  raddr,
  output logic [NCH-1:0] rdata
);
  logic [NCH-1:0] mem [DEPTH];

  // single write port, registered read port: block-RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hitro_fifo.sv
module hitro_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R5
  AST_FIFO_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R4
  AST_FIFO_OCC_LIMIT: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH)); // R4
endmodule

// File: rtl/hitro_ser.sv
module hitro_ser import hitro_pkg::*; #(
  parameter int NCH  = 254,
  localparam int EW  = ERR_W + CNT_W + NCH,
  localparam int PKT = OVH_W + NCH,
  localparam int BW  = $clog2(PKT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          empty,
  input  logic [EW-1:0] entry,
  output logic          pop,
  output logic          ser_out,
  output logic          active,
  output logic          tail
);
  logic [NCH-1:0] chan_msb0;
  logic [PKT-1:0] sreg;
  logic [BW-1:0]  bcnt;

  // channel 0 must leave first, so it goes to the top of the field
  for (genvar i = 0; i < NCH; i++) begin : g_rev
    assign chan_msb0[NCH-1-i] = entry[i];
  end

  assign pop = !active && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      bcnt    <= '0;
      active  <= 1'b0;
      ser_out <= 1'b0;
      tail    <= 1'b0;
    end else begin
      tail <= active;
      if (active) begin
        ser_out <= sreg[PKT-1];
        sreg    <= {sreg[PKT-2:0], 1'b0};
        bcnt    <= bcnt - 1'b1;
        if (bcnt == '0) active <= 1'b0;
      end else begin
        ser_out <= 1'b0;
        if (pop) begin
          sreg   <= {START_HDR, entry[EW-1:NCH], chan_msb0};
          bcnt   <= BW'(PKT - 1);
          active <= 1'b1;
        end
      end
    end
  end

  AST_START_HDR: assert property (@(posedge clk) disable iff (rst) pop |=> ##1 ser_out); // R2
endmodule

// File: rtl/hit_readout.sv
module hit_readout import hitro_pkg::*; #(
  parameter int NCH        = 254,
  parameter int DEPTH      = 512,
  parameter int FIFO_DEPTH = 16,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bx_en,
  input  logic [NCH-1:0] hits,
  input  logic           trig,
  input  logic [AW-1:0]  latency,
  output logic           ser_out,
  output logic           busy,
  output logic           overflow
);
  localparam int EW = ERR_W + CNT_W + NCH;

  logic [AW-1:0]  wptr, raddr;
  logic [AW:0]    rsum;
  logic [NCH-1:0] rd_hits;
  logic           trig_d, lat_bad_d, ovf_q;
  trig_cnt_t      cnt_q;
  logic           accept, drop;
  logic [EW-1:0]  fifo_din, fifo_dout;
  logic           fifo_empty, fifo_full, fifo_pop;
  logic           ser_active, ser_tail;

  // read slot = write slot minus latency, modulo DEPTH
  always_comb begin
    rsum  = {1'b0, wptr} + (AW+1)'(DEPTH) - {1'b0, latency};
    raddr = (rsum >= (AW+1)'(DEPTH)) ? AW'(rsum - (AW+1)'(DEPTH)) : AW'(rsum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      trig_d    <= 1'b0;
      lat_bad_d <= 1'b0;
      cnt_q     <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (bx_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      trig_d    <= bx_en && trig;
      lat_bad_d <= (latency == '0);
      if (accept) cnt_q <= cnt_q + 1'b1;
      if (drop)   ovf_q <= 1'b1;
    end
  end

  assign accept   = trig_d && !fifo_full;
  assign drop     = trig_d && fifo_full;
  assign fifo_din = {ovf_q, lat_bad_d, cnt_q, rd_hits};

  hitro_pipe_ram #(.NCH(NCH), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (bx_en),
    .waddr (wptr),
    .wdata (hits),
    .re    (bx_en && trig),
    .raddr (raddr),
    .rdata (rd_hits)
  );

  hitro_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (accept),
    .din   (fifo_din),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  hitro_ser #(.NCH(NCH)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .empty   (fifo_empty),
    .entry   (fifo_dout),
    .pop     (fifo_pop),
    .ser_out (ser_out),
    .active  (ser_active),
    .tail    (ser_tail)
  );

  assign busy     = ser_active || !fifo_empty || ser_tail;
  assign overflow = ovf_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) accept |=> cnt_q == trig_cnt_t'($past(cnt_q) + 1'b1)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst) !accept |=> $stable(cnt_q)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) ovf_q |=> ovf_q); // R5
  AST_QUIET_LINE: assert property (@(posedge clk) disable iff (rst) !busy |-> !ser_out); // R7
endmodule

// File: tb/hit_readout_test.sv
module hit_readout_test;
  localparam int NCH = 20;
  localparam int DEPTH = 64;
  localparam int FD = 4;
  localparam int AW = $clog2(DEPTH);
  localparam int PKT = 13 + NCH;
  localparam int HS = 4096;

  logic clk = 1'b0, rst = 1'b1, bx_en = 1'b0, trig = 1'b0;
  logic [NCH-1:0] hits = '0;
  logic [AW-1:0] latency = AW'(1);
  logic ser_out, busy, overflow;

  int n_tests = 0, n_fail = 0;
  int n = 0, est = 0, n_sent = 0, n_rcv = 0, drops = 0, acc = 0;
  bit done = 0, mon_on = 0;
  logic [NCH-1:0] hist [HS];
  logic [NCH-1:0] q_data [$];
  bit q_lerr [$];

  always #2 clk = ~clk;

  hit_readout #(.NCH(NCH), .DEPTH(DEPTH), .FIFO_DEPTH(FD)) uut (
    .clk(clk), .rst(rst), .bx_en(bx_en), .hits(hits), .trig(trig),
    .latency(latency), .ser_out(ser_out), .busy(busy), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [NCH-1:0] rev(input logic [NCH-1:0] v);
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[NCH-1-i] = v[i];
    return r;
  endfunction

  task automatic check_pkt(input logic [PKT-1:0] pk);
    logic [1:0] hdr = pk[PKT-1:PKT-2];
    logic [1:0] err = pk[PKT-3:PKT-4];
    logic [8:0] cnt = pk[PKT-5:PKT-13];
    logic [NCH-1:0] dat = pk[NCH-1:0];
    bit found = 0, lerr = 0;
    n_rcv++;
    chk(hdr == 2'b11, "R2 header", hdr, 3);
    while (q_data.size() > 0 && !found) begin
      logic [NCH-1:0] e = q_data.pop_front();
      bit le = q_lerr.pop_front();
      if (le || rev(e) == dat) begin
        found = 1;
        lerr = le;
      end else drops++;
    end
    chk(found, "R1/R4 packet matches a pending trigger", dat, 0);
    chk(cnt == 9'(acc), "R3 trigger number", cnt, acc % 512);
    chk(err[1] == (drops > 0), "R5 overflow error bit", err[1], drops > 0);
    chk(err[0] == lerr, "R6 latency error bit", err[0], lerr);
    acc++;
  endtask

  // stream decoder
  logic [PKT-1:0] pk;
  int nb = 0;
  bit in_pkt = 0, just_end = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (just_end) begin
        chk(ser_out == 1'b0, "R7 gap after packet", ser_out, 0);
        just_end = 0;
      end else if (!in_pkt) begin
        if (ser_out) begin
          in_pkt = 1;
          pk = '0;
          pk[0] = 1'b1;
          nb = 1;
        end
      end else begin
        pk = {pk[PKT-2:0], ser_out};
        nb++;
        if (nb == PKT) begin
          check_pkt(pk);
          in_pkt = 0;
          just_end = 1;
        end
      end
    end
  end

  // one bunch crossing: 8 clocks, sampling strobe in the first (R10: noise elsewhere)
  task automatic bx(input bit t, input bit offt);
    logic [NCH-1:0] h = NCH'($urandom);
    @(negedge clk);
    bx_en = 1'b1; hits = h; trig = t;
    hist[n % HS] = h;
    if (t) begin
      q_data.push_back(hist[(n - int'(latency)) % HS]);
      q_lerr.push_back(latency == '0);
      n_sent++;
    end
    n++;
    @(negedge clk);
    bx_en = 1'b0; trig = 1'b0; hits = ~h;
    repeat (2) @(negedge clk);
    trig = offt;
    @(negedge clk);
    trig = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain();
    int w = 0;
    while (busy && w < 20000) begin @(negedge clk); w++; end
    repeat (20) @(negedge clk);
    est = 0;
  endtask

  task automatic rand_phase(input int nbx, input int lat, input int prob);
    latency = AW'(lat);
    for (int i = 0; i < nbx; i++) begin
      bit t;
      if (n % 5 == 0 && est > 0) est--;
      t = (int'($urandom % 100) < prob) && (est < 3);
      if (t) est++;
      bx(t, 0);
    end
    drain();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(ser_out == 0 && busy == 0 && overflow == 0, "R9 in reset", {ser_out, busy, overflow}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ser_out == 0 && busy == 0 && overflow == 0, "R9 after reset", {ser_out, busy, overflow}, 0);
    mon_on = 1;

    for (int i = 0; i < 70; i++) bx(0, 0);

    // R8: busy rises with a single trigger
    latency = AW'(3);
    bx(1, 0);
    chk(busy == 1'b1, "R8 busy while sending", busy, 1);
    drain();
    chk(busy == 1'b0, "R8 idle after drain", busy, 0);

    // R1 latency extremes and mid values, random trigger spacing
    rand_phase(400, 5, 40);
    rand_phase(400, 1, 50);
    rand_phase(400, DEPTH - 1, 50);
    rand_phase(1600, 17, 50);
    chk(drops == 0, "R4 no loss with room in queue", drops, 0);
    chk(n_rcv == n_sent, "R4 every trigger delivered", n_rcv, n_sent);
    chk(acc > 512, "R3 counter wrap exercised", acc, 513);

    // R10: strobes off the sampling cycle
    latency = AW'(9);
    for (int i = 0; i < 20; i++) bx(0, 1);
    drain();
    chk(n_rcv == n_sent, "R10 off-strobe triggers ignored", n_rcv, n_sent);

    // R6: zero latency flags the packet
    latency = '0;
    bx(1, 0);
    latency = AW'(9);
    drain();
    chk(n_rcv == n_sent, "R6 flagged packet delivered", n_rcv, n_sent);
    chk(overflow == 1'b0, "R5 no overflow yet", overflow, 0);

    // R5: back-to-back burst overfills the queue
    latency = AW'(12);
    for (int i = 0; i < 14; i++) bx(1, 0);
    drain();
    chk(drops > 0, "R5 burst dropped triggers", drops, 1);
    chk(overflow == 1'b1, "R5 sticky overflow", overflow, 1);
    bx(1, 0);
    drain();
    chk(overflow == 1'b1, "R5 overflow still set", overflow, 1);
    chk(q_data.size() == 0, "R4 queue drained", q_data.size(), 0);
    chk(busy == 1'b0, "R8 idle at end", busy, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule